// File: doc/BRIEF.md
# Banked Scratchpad Operand Conflict Classifier

This block looks at the three operand addresses of one vector instruction (two sources and one destination) and decides whether their first 32-byte blocks collide inside a 192 KB scratchpad. The scratchpad is built from 48 banks of 128 rows of 32 bytes. The banks are arranged as 16 bank groups of three banks each. Each address is split into a bank-group index and a global bank index, and both indices are reported for every operand.

Two kinds of collision are flagged. A source and the destination that land in the same bank form a read/write conflict. Two sources that land in the same bank group form a read/read conflict, even when their banks differ. A stall flag is the OR of the two. Each operand carries a valid bit, and an operand whose bit is low takes part in no comparison. If any valid operand lies outside the 192 KB window, an error flag is raised and every conflict output is held low. An issue stage uses the flags to decide whether an instruction can start in the next cycle. When the parameter `REG_OUT` is 1 (the default), all outputs pass through one register stage.

Top module: `bank_conflict_cls`

## Requirements
- R1: The group output of each operand equals byte-address bits [8:5], which gives a value from 0 to 15.
- R2: The bank output of each operand equals slot*16 + group, where slot is the address divided by 0x10000. For example, 0x10000 maps to bank 16, 0x10020 to bank 17, 0x20020 to bank 33, and 0x10E20 to bank 17 in group 1. An address at or above 0x30000 gives slot 3 and a bank value of 48 to 63.
- R3: `range_err_o` is 1 exactly when at least one operand with its valid bit high has an address at or above 0x30000. An out-of-range address on an invalid operand raises no error.
- R4: While `range_err_o` is 1, `rw_conf_o`, `rr_conf_o` and `stall_o` are all 0.
- R5: `rw_conf_o` is 1 when the destination is valid and at least one valid source has the same bank index as the destination.
- R6: A source that shares only the bank group with the destination, and not the bank, causes no read/write conflict.
- R7: `rr_conf_o` is 1 when both sources are valid and their group indices are equal, whether or not their banks are equal.
- R8: An operand whose valid bit is 0 causes neither conflict flag, whatever its address.
- R9: `stall_o` equals `rw_conf_o` OR `rr_conf_o`.
- R10: With `REG_OUT`=1, every output reflects the inputs sampled at the previous rising clock edge. While `rst_ni` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src0_addr_i | input | 18 | Byte address of the first source |
| src1_addr_i | input | 18 | Byte address of the second source |
| dst_addr_i | input | 18 | Byte address of the destination |
| src0_vld_i | input | 1 | First source present |
| src1_vld_i | input | 1 | Second source present |
| dst_vld_i | input | 1 | Destination present |
| src0_grp_o | output | 4 | Bank group of the first source |
| src0_bank_o | output | 6 | Global bank of the first source |
| src1_grp_o | output | 4 | Bank group of the second source |
| src1_bank_o | output | 6 | Global bank of the second source |
| dst_grp_o | output | 4 | Bank group of the destination |
| dst_bank_o | output | 6 | Global bank of the destination |
| rw_conf_o | output | 1 | Read/write conflict on a shared bank |
| rr_conf_o | output | 1 | Read/read conflict on a shared group |
| stall_o | output | 1 | Either conflict present |
| range_err_o | output | 1 | A valid operand lies outside the buffer |

## Verification
A wrong address split shows up at once, because the group and bank outputs are wrong one cycle after the address is presented. A comparison that uses the wrong granularity shows up as a false flag. If read/write is judged by group, a `rw_conf_o` appears for same-group pairs in different slots. If read/read is judged by bank, `rr_conf_o` is missed for those same pairs. The bench biases its random operands toward shared groups and shared banks so that both of these mistakes are reached in the first few hundred cycles. Faults in valid masking or in error suppression appear as a flag in the cycle right after the stimulus that should have silenced it.

// File: rtl/bank_conflict_pkg.sv
package bank_conflict_pkg;
  typedef struct packed {
    logic rw;
    logic rr;
    logic stall;
    logic err;
  } conf_flags_t;
  localparam int unsigned FLAGS_W = $bits(conf_flags_t);
endpackage

// File: rtl/bank_addr_map.sv
module bank_addr_map #(
  parameter int unsigned ADDR_W    = 18,
  parameter int unsigned ROW_LOG2  = 5,
  parameter int unsigned GRP_W     = 4,
  parameter int unsigned SLOT_LOG2 = 16,
  parameter int unsigned NUM_SLOTS = 3,
  localparam int unsigned SLOT_W   = ADDR_W - SLOT_LOG2,
  localparam int unsigned BANK_W   = SLOT_W + GRP_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              vld_i,
  output logic [GRP_W-1:0]  grp_o,
  output logic [BANK_W-1:0] bank_o,
  output logic              oor_o
);
  logic [SLOT_W-1:0] slot;

  assign slot   = addr_i[ADDR_W-1:SLOT_LOG2];
  assign grp_o  = addr_i[ROW_LOG2 +: GRP_W];
  // groups are a power of two, so slot*groups+grp is a concatenation
  assign bank_o = {slot, grp_o};
  assign oor_o  = vld_i && (32'(slot) >= NUM_SLOTS);
endmodule

// File: rtl/bank_conflict_cmp.sv
module bank_conflict_cmp
  import bank_conflict_pkg::*;
#(
  parameter int unsigned GRP_W  = 4,
  parameter int unsigned BANK_W = 6
) (
  input  logic [GRP_W-1:0]  s0_grp_i,
  input  logic [GRP_W-1:0]  s1_grp_i,
  input  logic [BANK_W-1:0] s0_bank_i,
  input  logic [BANK_W-1:0] s1_bank_i,
  input  logic [BANK_W-1:0] d_bank_i,
  input  logic              s0_vld_i,
  input  logic              s1_vld_i,
  input  logic              d_vld_i,
  input  logic [2:0]        oor_i,
  output conf_flags_t       flags_o
);
  logic err, rw_raw, rr_raw;

  assign err    = |oor_i;
  // read vs write: full bank match
  assign rw_raw = d_vld_i && ((s0_vld_i && s0_bank_i == d_bank_i) ||
                              (s1_vld_i && s1_bank_i == d_bank_i));
  // read vs read: group match only
  assign rr_raw = s0_vld_i && s1_vld_i && (s0_grp_i == s1_grp_i);

  always_comb begin
    flags_o.err   = err;
    flags_o.rw    = rw_raw && !err;
    flags_o.rr    = rr_raw && !err;
    flags_o.stall = (rw_raw || rr_raw) && !err;
  end

  always_comb begin
    if (flags_o.rw)
      AST_RW_BANK_MATCH: assert (d_vld_i && (d_bank_i == s0_bank_i || d_bank_i == s1_bank_i)); // R5
    if (flags_o.rr)
      AST_RR_BOTH_VALID: assert (s0_vld_i && s1_vld_i); // R8
  end
endmodule

// File: rtl/bank_out_stage.sv
module bank_out_stage #(
  parameter int unsigned W       = 8,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_o <= '0;
      else         q_o <= d_i;
    end
  end else begin : g_comb
    assign q_o = d_i;
  end
endmodule

// File: rtl/bank_conflict_cls.sv
module bank_conflict_cls
  import bank_conflict_pkg::*;
#(
  parameter int unsigned ADDR_W    = 18,
  parameter int unsigned ROW_LOG2  = 5,
  parameter int unsigned GRP_W     = 4,
  parameter int unsigned SLOT_LOG2 = 16,
  parameter int unsigned NUM_SLOTS = 3,
  parameter bit          REG_OUT   = 1'b1,
  localparam int unsigned BANK_W   = ADDR_W - SLOT_LOG2 + GRP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] src0_addr_i,
  input  logic [ADDR_W-1:0] src1_addr_i,
  input  logic [ADDR_W-1:0] dst_addr_i,
  input  logic              src0_vld_i,
  input  logic              src1_vld_i,
  input  logic              dst_vld_i,
  output logic [GRP_W-1:0]  src0_grp_o,
  output logic [BANK_W-1:0] src0_bank_o,
  output logic [GRP_W-1:0]  src1_grp_o,
  output logic [BANK_W-1:0] src1_bank_o,
  output logic [GRP_W-1:0]  dst_grp_o,
  output logic [BANK_W-1:0] dst_bank_o,
  output logic              rw_conf_o,
  output logic              rr_conf_o,
  output logic              stall_o,
  output logic              range_err_o
);
  localparam int unsigned NOPS  = 3;
  localparam int unsigned OUT_W = NOPS * (GRP_W + BANK_W) + FLAGS_W;

  logic [NOPS-1:0][ADDR_W-1:0] op_addr;
  logic [NOPS-1:0]             op_vld, op_oor;
  logic [NOPS-1:0][GRP_W-1:0]  op_grp;
  logic [NOPS-1:0][BANK_W-1:0] op_bank;
  conf_flags_t                 flags_c, flags_q;
  logic [OUT_W-1:0]            out_d, out_q;

  assign op_addr = {dst_addr_i, src1_addr_i, src0_addr_i};
  assign op_vld  = {dst_vld_i, src1_vld_i, src0_vld_i};

  for (genvar i = 0; i < NOPS; i++) begin : g_map
    bank_addr_map #(
      .ADDR_W(ADDR_W), .ROW_LOG2(ROW_LOG2), .GRP_W(GRP_W),
      .SLOT_LOG2(SLOT_LOG2), .NUM_SLOTS(NUM_SLOTS)
    ) u_map (
      .addr_i(op_addr[i]), .vld_i(op_vld[i]),
      .grp_o(op_grp[i]), .bank_o(op_bank[i]), .oor_o(op_oor[i])
    );
  end

  bank_conflict_cmp #(.GRP_W(GRP_W), .BANK_W(BANK_W)) u_cmp (
    .s0_grp_i(op_grp[0]), .s1_grp_i(op_grp[1]),
    .s0_bank_i(op_bank[0]), .s1_bank_i(op_bank[1]), .d_bank_i(op_bank[2]),
    .s0_vld_i(op_vld[0]), .s1_vld_i(op_vld[1]), .d_vld_i(op_vld[2]),
    .oor_i(op_oor), .flags_o(flags_c)
  );

  assign out_d = {op_grp, op_bank, flags_c};

  bank_out_stage #(.W(OUT_W), .REG_OUT(REG_OUT)) u_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(out_d), .q_o(out_q)
  );

  assign {dst_grp_o, src1_grp_o, src0_grp_o,
          dst_bank_o, src1_bank_o, src0_bank_o, flags_q} = out_q;
  assign rw_conf_o   = flags_q.rw;
  assign rr_conf_o   = flags_q.rr;
  assign stall_o     = flags_q.stall;
  assign range_err_o = flags_q.err;

  AST_STALL_IS_OR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o == (rw_conf_o || rr_conf_o)); // R9
  AST_ERR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    range_err_o |-> !(rw_conf_o || rr_conf_o || stall_o)); // R4

  if (REG_OUT) begin : g_chk
    AST_RR_PAST_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rr_conf_o |-> $past(src0_vld_i && src1_vld_i)); // R8
    AST_RW_PAST_DST: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rw_conf_o |-> $past(dst_vld_i)); // R5
    AST_GRP_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(rst_ni) |-> src0_grp_o == $past(src0_addr_i[ROW_LOG2 +: GRP_W])); // R1
  end
endmodule

// File: tb/bank_conflict_cls_bench.sv
module bank_conflict_cls_bench;
  logic clk = 0, rst_n = 0;
  logic [17:0] a0, a1, ad;
  logic v0, v1, vd;
  logic [3:0] g0, g1, gd;
  logic [5:0] b0, b1, bd;
  logic rw, rr, st, er;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  bank_conflict_cls u_bank_conflict_cls (
    .clk_i(clk), .rst_ni(rst_n),
    .src0_addr_i(a0), .src1_addr_i(a1), .dst_addr_i(ad),
    .src0_vld_i(v0), .src1_vld_i(v1), .dst_vld_i(vd),
    .src0_grp_o(g0), .src0_bank_o(b0), .src1_grp_o(g1), .src1_bank_o(b1),
    .dst_grp_o(gd), .dst_bank_o(bd),
    .rw_conf_o(rw), .rr_conf_o(rr), .stall_o(st), .range_err_o(er)
  );

  function automatic logic [3:0] m_grp(logic [17:0] a);
    return 4'((a / 32) % 16);
  endfunction
  function automatic logic [5:0] m_bank(logic [17:0] a);
    return 6'((a / 18'h10000) * 16 + m_grp(a));
  endfunction
  function automatic logic m_oor(logic [17:0] a, logic v);
    return v && (a >= 18'h30000);
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // drive at negedge, check at next negedge (one register stage, R10)
  task automatic apply(logic [17:0] x0, logic [17:0] x1, logic [17:0] xd,
                       logic y0, logic y1, logic yd);
    logic e_err, e_rw, e_rr;
    a0 = x0; a1 = x1; ad = xd; v0 = y0; v1 = y1; vd = yd;
    @(negedge clk);
    e_err = m_oor(x0, y0) || m_oor(x1, y1) || m_oor(xd, yd);
    e_rw  = !e_err && yd && ((y0 && m_bank(x0) == m_bank(xd)) ||
                             (y1 && m_bank(x1) == m_bank(xd)));
    e_rr  = !e_err && y0 && y1 && m_grp(x0) == m_grp(x1);
    chk("R1", "src0_grp", g0, m_grp(x0));
    chk("R1", "src1_grp", g1, m_grp(x1));
    chk("R1", "dst_grp",  gd, m_grp(xd));
    chk("R2", "src0_bank", b0, m_bank(x0));
    chk("R2", "src1_bank", b1, m_bank(x1));
    chk("R2", "dst_bank",  bd, m_bank(xd));
    chk("R3", "range_err", er, e_err);
    chk("R5", "rw_conf", rw, e_rw);
    chk("R7", "rr_conf", rr, e_rr);
    chk("R9", "stall", st, e_rw || e_rr);
  endtask

  function automatic logic [17:0] rnd_addr();
    if ($urandom % 10 == 0) return 18'h30000 + 18'($urandom % 18'h10000);
    return 18'($urandom % 18'h30000);
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [17:0] x0, x1, xd;
    void'($urandom(32'd1234));
    a0 = 18'h3FFFF; a1 = 18'h3FFFF; ad = 18'h3FFFF; v0 = 1; v1 = 1; vd = 1;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", "reset outputs", {g0, b0, g1, b1, gd, bd, rw, rr, st, er}, 0);
    rst_n = 1;
    @(negedge clk);

    // R2 fixed map points
    apply(18'h10000, 18'h10020, 18'h20020, 0, 0, 0);
    chk("R2", "0x10000 bank", b0, 16);
    chk("R2", "0x10020 bank", b1, 17);
    chk("R2", "0x20020 bank", bd, 33);
    apply(18'h10E20, 18'h0, 18'h0, 0, 0, 0);
    chk("R2", "0x10E20 bank", b0, 17);
    chk("R1", "0x10E20 grp", g0, 1);
    // R5 same bank read vs write
    apply(18'h10020, 18'h10000, 18'h10E20, 1, 1, 1);
    chk("R5", "rw same bank", rw, 1);
    chk("R7", "rr diff group", rr, 0);
    // R6 same group, different slot, no rw
    apply(18'h10020, 18'h00000, 18'h20020, 1, 0, 1);
    chk("R6", "rw group only", rw, 0);
    // R7 same group, different bank
    apply(18'h10020, 18'h20020, 18'h00100, 1, 1, 1);
    chk("R7", "rr cross bank", rr, 1);
    // R8 invalid operands excluded
    apply(18'h10020, 18'h10020, 18'h10020, 1, 0, 1);
    chk("R8", "rr src1 invalid", rr, 0);
    apply(18'h10020, 18'h10020, 18'h10020, 1, 1, 0);
    chk("R8", "rw dst invalid", rw, 0);
    chk("R9", "stall rr only", st, 1);
    // R3 invalid out-of-range operand raises no error
    apply(18'h00020, 18'h00020, 18'h3FFE0, 1, 1, 0);
    chk("R3", "oor on invalid", er, 0);
    // R4 valid out-of-range suppresses conflicts
    apply(18'h00020, 18'h00020, 18'h30000, 1, 1, 1);
    chk("R4", "err raised", er, 1);
    chk("R4", "stall suppressed", st, 0);
    apply(18'h2FFFF, 18'h2FFE0, 18'h2FFFF, 1, 1, 1);
    chk("R3", "top edge in range", er, 0);

    for (int i = 0; i < 3000; i++) begin
      x0 = rnd_addr();
      x1 = rnd_addr();
      xd = rnd_addr();
      case ($urandom % 4)
        0: x1 = {x1[17:9], x0[8:5], x1[4:0]};
        1: xd = {x0[17:16], xd[15:9], x0[8:5], xd[4:0]};
        2: xd = {xd[17:16], xd[15:9], x1[8:5], xd[4:0]};
        default: ;
      endcase
      apply(x0, x1, xd, 1'($urandom % 5 != 0), 1'($urandom % 5 != 0),
            1'($urandom % 5 != 0));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule